// File: doc/BRIEF.md
# Latchable Bidirectional Parity Transceiver

This block moves a byte plus one parity bit between two sides, A and B. Each side has a capture register that stands in for a transparent latch, and each side has its own active-low output enable and its own active-low parity error flag. When a side's latch enable is high, the live word on that side is used and is also captured at each clock edge. When the enable is low, the last captured word is used. A select input sets the mode. In generate mode the outgoing parity bit is computed from the eight data bits. In feed-through mode the incoming parity bit is copied to the other side unchanged. A second input chooses between odd and even parity.

The pads are not modelled as tri-state pins. Each side has separate input, output and output-valid ports, and the outgoing word is always present on the output port. A link mode is decoded on every cycle from the two output enables. The modes are `LINK_ISOLATE` (neither side driven), `LINK_A_TO_B` (B driven), `LINK_B_TO_A` (A driven) and `LINK_LOOPBACK` (both driven). Any mode can change to any other mode in the next cycle when the enables change. There are no other transitions.

In `LINK_LOOPBACK`, each forward path takes its word from the opposite side's captured register. This register holds the word that was driven in the previous cycle. Each side's latch and error check see the word the block drives onto that side, so the parity written onto a bus is checked again on the way back.

Top module: `parity_xcvr`

## Requirements
- R1: After reset both capture registers hold zero. With both latch enables low, generate mode and even sense, both outputs show data 0x00 with parity 0, and both error flags are high.
- R2: With a side's latch enable high, that side's live word (the driven word if the block drives that side, otherwise the input port) is used and is captured at the clock edge. With the enable low, the word captured at the last edge where it was high is used, and later changes on the input have no effect.
- R3: `a_oe_o` is high exactly when `oe_ba_n` is low, and `b_oe_o` is high exactly when `oe_ab_n` is low. The data and parity outputs carry the forward word whatever the enables are.
- R4: With `feed_sel` low, each output data byte equals the source side's selected data byte, and the output parity bit is generated from that byte.
- R5: With `feed_sel` high, the output parity bit equals the source side's selected parity bit.
- R6: With `odd_sel` low, data holding an even number of ones generates parity 0. With `odd_sel` high, the same data generates parity 1. So the nine bits {parity, data} then contain an odd number of ones exactly when `odd_sel` is high.
- R7: `err_a_n` (and likewise `err_b_n`) is low exactly when the selected nine-bit word on that side has a ones count whose parity differs from `odd_sel`.
- R8: With both output enables low, the block drives A from B's captured word and drives B from A's captured word. Each side's latch and error flag see the driven word, so in generate mode with a transparent latch that side's flag stays high.
- R9: In feed-through mode the check is still made. A word with bad parity passes through unchanged and pulls the receiving side's error flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the capture registers |
| rst_n | input | 1 | Active-low synchronous reset |
| oe_ab_n | input | 1 | Active low: drive side B from side A |
| oe_ba_n | input | 1 | Active low: drive side A from side B |
| le_ab | input | 1 | Side A latch enable (high = transparent) |
| le_ba | input | 1 | Side B latch enable (high = transparent) |
| feed_sel | input | 1 | 0 = generate parity, 1 = feed parity through |
| odd_sel | input | 1 | Parity sense, 0 = even, 1 = odd |
| a_data_i | input | DATA_W | Data from side A pads |
| a_par_i | input | 1 | Parity from side A pads |
| a_data_o | output | DATA_W | Data toward side A pads |
| a_par_o | output | 1 | Parity toward side A pads |
| a_oe_o | output | 1 | Side A output valid |
| b_data_i | input | DATA_W | Data from side B pads |
| b_par_i | input | 1 | Parity from side B pads |
| b_data_o | output | DATA_W | Data toward side B pads |
| b_par_o | output | 1 | Parity toward side B pads |
| b_oe_o | output | 1 | Side B output valid |
| err_a_n | output | 1 | Active-low parity error on side A |
| err_b_n | output | 1 | Active-low parity error on side B |

## Verification
The assertions check four rules on every cycle:
- generated parity on B is consistent with `odd_sel`;
- in feed-through mode the live A parity is copied to B;
- the A-side error flag matches a live, undriven A word;
- the B data output holds still while A's latch stays closed.

They also check that a loopback in generate mode never flags side A. Other behaviours only show up in the bench's scenarios. These are the exact word captured before a latch closes, the one-cycle delay through the captured registers in loopback, the reset contents, and the full 0-to-8 ones sweep under both senses and both modes.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
    typedef enum logic [1:0] {
        LINK_ISOLATE  = 2'b00,
        LINK_A_TO_B   = 2'b01,
        LINK_B_TO_A   = 2'b10,
        LINK_LOOPBACK = 2'b11
    } link_mode_t;
endpackage

// File: rtl/bus_latch.sv
module bus_latch #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] held_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_o <= '0;
        end else if (le_i) begin
            held_o <= word_i;
        end
    end
endmodule

// File: rtl/parity_flag.sv
module parity_flag #(
    parameter int WORD_W = 9
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              odd_i,
    output logic              err_n_o
);
    always_comb begin
        err_n_o = ((^word_i) == odd_i);
    end
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_ab_n,
    input  logic              oe_ba_n,
    input  logic              le_ab,
    input  logic              le_ba,
    input  logic              feed_sel,
    input  logic              odd_sel,
    input  logic [DATA_W-1:0] a_data_i,
    input  logic              a_par_i,
    output logic [DATA_W-1:0] a_data_o,
    output logic              a_par_o,
    output logic              a_oe_o,
    input  logic [DATA_W-1:0] b_data_i,
    input  logic              b_par_i,
    output logic [DATA_W-1:0] b_data_o,
    output logic              b_par_o,
    output logic              b_oe_o,
    output logic              err_a_n,
    output logic              err_b_n
);
    import ptx_pkg::*;

    localparam int WORD_W = DATA_W + 1;

    link_mode_t        mode;
    logic [WORD_W-1:0] held_a, held_b;
    logic [WORD_W-1:0] a_bus, b_bus, a_view, b_view, a_out, b_out;

    function automatic logic [WORD_W-1:0] enc_word(
        input logic [WORD_W-1:0] src,
        input logic              thru,
        input logic              odd
    );
        logic p;
        p = thru ? src[DATA_W] : ((^src[DATA_W-1:0]) ^ odd);
        return {p, src[DATA_W-1:0]};
    endfunction

    // link mode decode, re-evaluated every cycle
    always_comb begin
        unique case ({~oe_ba_n, ~oe_ab_n})
            2'b00:   mode = LINK_ISOLATE;
            2'b01:   mode = LINK_A_TO_B;
            2'b10:   mode = LINK_B_TO_A;
            default: mode = LINK_LOOPBACK;
        endcase
    end

    // datapath, ordered per mode so no word depends on itself
    always_comb begin
        a_bus  = '0;
        b_bus  = '0;
        a_view = '0;
        b_view = '0;
        a_out  = '0;
        b_out  = '0;
        unique case (mode)
            LINK_ISOLATE, LINK_A_TO_B: begin
                a_bus  = {a_par_i, a_data_i};
                a_view = le_ab ? a_bus : held_a;
                b_out  = enc_word(a_view, feed_sel, odd_sel);
                b_bus  = (mode == LINK_A_TO_B) ? b_out : {b_par_i, b_data_i};
                b_view = le_ba ? b_bus : held_b;
                a_out  = enc_word(b_view, feed_sel, odd_sel);
            end
            LINK_B_TO_A: begin
                b_bus  = {b_par_i, b_data_i};
                b_view = le_ba ? b_bus : held_b;
                a_out  = enc_word(b_view, feed_sel, odd_sel);
                a_bus  = a_out;
                a_view = le_ab ? a_bus : held_a;
                b_out  = enc_word(a_view, feed_sel, odd_sel);
            end
            LINK_LOOPBACK: begin
                a_out  = enc_word(held_b, feed_sel, odd_sel);
                b_out  = enc_word(held_a, feed_sel, odd_sel);
                a_bus  = a_out;
                b_bus  = b_out;
                a_view = le_ab ? a_bus : held_a;
                b_view = le_ba ? b_bus : held_b;
            end
        endcase
    end

    always_comb begin
        a_data_o = a_out[DATA_W-1:0];
        a_par_o  = a_out[DATA_W];
        b_data_o = b_out[DATA_W-1:0];
        b_par_o  = b_out[DATA_W];
        a_oe_o   = (mode == LINK_B_TO_A) || (mode == LINK_LOOPBACK);
        b_oe_o   = (mode == LINK_A_TO_B) || (mode == LINK_LOOPBACK);
    end

    bus_latch #(.WORD_W(WORD_W)) u_latch_a (
        .clk(clk), .rst_n(rst_n), .le_i(le_ab), .word_i(a_bus), .held_o(held_a)
    );
    bus_latch #(.WORD_W(WORD_W)) u_latch_b (
        .clk(clk), .rst_n(rst_n), .le_i(le_ba), .word_i(b_bus), .held_o(held_b)
    );

    parity_flag #(.WORD_W(WORD_W)) u_flag_a (
        .word_i(a_view), .odd_i(odd_sel), .err_n_o(err_a_n)
    );
    parity_flag #(.WORD_W(WORD_W)) u_flag_b (
        .word_i(b_view), .odd_i(odd_sel), .err_n_o(err_b_n)
    );

    // R4 R6
    gen_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !feed_sel |-> ((^{b_par_o, b_data_o}) == odd_sel));

    // R5
    feed_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_sel && le_ab && oe_ba_n) |-> (b_par_o == a_par_i));

    // R7
    err_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le_ab && oe_ba_n) |-> (err_a_n == ((^{a_par_i, a_data_i}) == odd_sel)));

    // R2
    hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ab && $past(!le_ab)) |-> $stable(b_data_o));

    // R8
    loop_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ab_n && !oe_ba_n && !feed_sel && le_ab) |-> err_a_n);
endmodule

// File: tb/parity_xcvr_bench.sv
`timescale 1ns/1ps
module parity_xcvr_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       oe_ab_n, oe_ba_n, le_ab, le_ba, feed_sel, odd_sel;
    logic [7:0] a_data_i, b_data_i, a_data_o, b_data_o;
    logic       a_par_i, b_par_i, a_par_o, b_par_o, a_oe_o, b_oe_o;
    logic       err_a_n, err_b_n;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    logic [8:0] m_held_a, m_held_b;

    always #2.5 clk = ~clk;

    parity_xcvr #(.DATA_W(8)) u_parity_xcvr (
        .clk(clk), .rst_n(rst_n), .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n),
        .le_ab(le_ab), .le_ba(le_ba), .feed_sel(feed_sel), .odd_sel(odd_sel),
        .a_data_i(a_data_i), .a_par_i(a_par_i), .a_data_o(a_data_o),
        .a_par_o(a_par_o), .a_oe_o(a_oe_o), .b_data_i(b_data_i),
        .b_par_i(b_par_i), .b_data_o(b_data_o), .b_par_o(b_par_o),
        .b_oe_o(b_oe_o), .err_a_n(err_a_n), .err_b_n(err_b_n)
    );

    function automatic logic [8:0] ref_enc(input logic [8:0] w, input logic fs, input logic od);
        return {fs ? w[8] : ((^w[7:0]) ^ od), w[7:0]};
    endfunction

    task automatic check(input string tag, input string what, input logic [8:0] got, input logic [8:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic apply(input logic oeab, input logic oeba, input logic leab, input logic leba,
                         input logic fs, input logic od, input logic [7:0] ad, input logic ap,
                         input logic [7:0] bd, input logic bp, input string tag);
        logic [8:0] ab, bb, av, bv, ao, bo;
        @(negedge clk);
        oe_ab_n = oeab; oe_ba_n = oeba; le_ab = leab; le_ba = leba;
        feed_sel = fs; odd_sel = od;
        a_data_i = ad; a_par_i = ap; b_data_i = bd; b_par_i = bp;
        #1;
        if (!oeab && !oeba) begin
            ao = ref_enc(m_held_b, fs, od);
            bo = ref_enc(m_held_a, fs, od);
            ab = ao; bb = bo;
            av = leab ? ab : m_held_a;
            bv = leba ? bb : m_held_b;
        end else if (!oeba) begin
            bb = {bp, bd};
            bv = leba ? bb : m_held_b;
            ao = ref_enc(bv, fs, od);
            ab = ao;
            av = leab ? ab : m_held_a;
            bo = ref_enc(av, fs, od);
        end else begin
            ab = {ap, ad};
            av = leab ? ab : m_held_a;
            bo = ref_enc(av, fs, od);
            bb = !oeab ? bo : {bp, bd};
            bv = leba ? bb : m_held_b;
            ao = ref_enc(bv, fs, od);
        end
        check(tag, "a_out", {a_par_o, a_data_o}, ao);
        check(tag, "b_out", {b_par_o, b_data_o}, bo);
        check(tag, "oe", {7'd0, a_oe_o, b_oe_o}, {7'd0, !oeba, !oeab});
        check(tag, "err", {7'd0, err_a_n, err_b_n},
              {7'd0, ((^av) == od), ((^bv) == od)});
        if (leab) m_held_a = ab;
        if (leba) m_held_b = bb;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog run did not complete got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        oe_ab_n = 1; oe_ba_n = 1; le_ab = 0; le_ba = 0; feed_sel = 0; odd_sel = 0;
        a_data_i = 0; a_par_i = 0; b_data_i = 0; b_par_i = 0;
        m_held_a = '0; m_held_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset contents with latches closed
        apply(1, 1, 0, 0, 0, 0, 8'hA5, 1, 8'h3C, 1, "R1");

        // R4 R6 ones-count sweep, generate mode, both senses, both directions
        for (int od = 0; od < 2; od++) begin
            for (int k = 0; k <= 8; k++) begin
                apply(0, 1, 1, 1, 0, od[0], 8'((9'd1 << k) - 1), 0, 8'h00, 0, "R4");
                apply(1, 0, 1, 1, 0, od[0], 8'h00, 0, 8'((9'd1 << k) - 1), 1, "R6");
            end
        end

        // R5 R9 feed-through keeps parity, flags bad words
        for (int k = 0; k <= 8; k++) begin
            apply(0, 1, 1, 1, 1, k[0], 8'((9'd1 << k) - 1), k[1], 8'h11, 0, "R5");
            apply(0, 1, 1, 1, 1, 0, 8'h01, 0, 8'h00, 0, "R9");
        end

        // R2 capture then hold while the input moves
        apply(0, 1, 1, 0, 0, 0, 8'h5A, 0, 8'h00, 0, "R2");
        apply(0, 1, 0, 0, 0, 0, 8'hFF, 1, 8'h00, 0, "R2");
        apply(0, 1, 0, 0, 0, 0, 8'h07, 0, 8'h00, 0, "R2");
        apply(1, 0, 1, 0, 0, 1, 8'h00, 0, 8'hC3, 0, "R2");

        // R7 error on bad incoming word, odd and even
        apply(1, 1, 1, 1, 0, 0, 8'h03, 1, 8'h03, 0, "R7");
        apply(1, 1, 1, 1, 0, 1, 8'h03, 1, 8'h03, 0, "R7");

        // R3 isolation still presents the forward word
        apply(1, 1, 1, 1, 0, 0, 8'h81, 0, 8'h18, 1, "R3");

        // R8 loopback both generate and feed-through
        apply(0, 1, 1, 1, 0, 0, 8'h77, 1, 8'h00, 0, "R8");
        for (int i = 0; i < 6; i++) begin
            apply(0, 0, 1, 1, i[0], i[1], 8'h00, 0, 8'h00, 0, "R8");
        end
        apply(0, 0, 0, 1, 1, 0, 8'h00, 0, 8'h00, 0, "R8");

        // mixed random stimulus
        for (int i = 0; i < 3000; i++) begin
            apply($urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1),
                  $urandom_range(1), $urandom_range(1), 8'($urandom), $urandom_range(1),
                  8'($urandom), $urandom_range(1), "random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule